// File: doc/BRIEF.md
# Shared-Gate Bitwise Logic Unit

This block computes eight two-operand bitwise functions on 64-bit words using only three core gate arrays: one AND, one OR and one XOR. Two optional inverters produce the remaining forms. One sits on operand B, ahead of the core. The other sits on the core result. AND-with-complement and OR-with-complement come from inverting B. NAND, NOR and equivalence come from inverting the result.

The datapath is purely combinational and has no clock. A caller either drives the gate-group select and the two invert flags directly, or passes a named operation code through the companion decoder module, which produces those three control values.

A gate-group code of 3 is reserved. It forces the result to all zeros, whatever the invert flags are.

Top module: `lgu_logic_unit`

## Requirements
- R1: With `grp_sel` = 2'b00 and both invert flags low, `result` equals `opa & opb`.
- R2: With `grp_sel` = 2'b01 and both invert flags low, `result` equals `opa | opb`.
- R3: With `grp_sel` = 2'b10 and both invert flags low, `result` equals `opa ^ opb`.
- R4: With `inv_b` high, the selected core gate uses `~opb` in place of `opb` (for example, group 00 gives `opa & ~opb`).
- R5: With `inv_res` high and a non-reserved group, `result` is the bitwise complement of what the same inputs give with `inv_res` low.
- R6: `grp_sel` = 2'b11 makes `result` all zeros for every value of `opa`, `opb`, `inv_b` and `inv_res`.
- R7: The decoder `lgu_op_decode` maps each 3-bit operation code to {group, inv_b, inv_res} as follows:
  - 0 AND = {00,0,0}
  - 1 ANDC = {00,1,0}
  - 2 NAND = {00,0,1}
  - 3 OR = {01,0,0}
  - 4 ORC = {01,1,0}
  - 5 NOR = {01,0,1}
  - 6 XOR = {10,0,0}
  - 7 EQV = {10,0,1}
- R8: `result` follows a change on any input within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand, optionally inverted before the core |
| grp_sel | input | 2 | Core gate group: 00 AND, 01 OR, 10 XOR, 11 reserved |
| inv_b | input | 1 | Invert operand B before the core gate |
| inv_res | input | 1 | Invert the core gate output |
| result | output | 64 | Bitwise result |

## Verification
The all-zeros and all-ones operands, together with alternating bit patterns, are run through all eight named operations.

- An inverter placed on the wrong side of the core would make ANDC look like NAND. These patterns show that as whole-word mismatches.
- A swapped group code would show up the same way.

The reserved group is driven with every flag combination. A design that let the output inverter act there would return all ones instead of zero.

Inputs are changed with no clock edge before the result is read. Any registered stage would therefore show up as a stale value.

// File: rtl/lgu_pkg.sv
package lgu_pkg;
  typedef enum logic [1:0] {
    GRP_AND  = 2'b00,
    GRP_OR   = 2'b01,
    GRP_XOR  = 2'b10,
    GRP_RSVD = 2'b11
  } lgu_grp_e;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_ANDC = 3'd1,
    OP_NAND = 3'd2,
    OP_OR   = 3'd3,
    OP_ORC  = 3'd4,
    OP_NOR  = 3'd5,
    OP_XOR  = 3'd6,
    OP_EQV  = 3'd7
  } lgu_op_e;

  typedef struct packed {
    logic [1:0] grp;
    logic       inv_b;
    logic       inv_res;
  } lgu_ctrl_t;
endpackage

// File: rtl/lgu_op_decode.sv
module lgu_op_decode
  import lgu_pkg::*;
(
  input  logic [2:0] op_code,
  output logic [1:0] grp_sel,
  output logic       inv_b,
  output logic       inv_res
);
  lgu_ctrl_t ctrl;

  always_comb begin
    ctrl = '0;
    unique case (lgu_op_e'(op_code))
      OP_AND:  ctrl = '{grp: GRP_AND, inv_b: 1'b0, inv_res: 1'b0};
      OP_ANDC: ctrl = '{grp: GRP_AND, inv_b: 1'b1, inv_res: 1'b0};
      OP_NAND: ctrl = '{grp: GRP_AND, inv_b: 1'b0, inv_res: 1'b1};
      OP_OR:   ctrl = '{grp: GRP_OR,  inv_b: 1'b0, inv_res: 1'b0};
      OP_ORC:  ctrl = '{grp: GRP_OR,  inv_b: 1'b1, inv_res: 1'b0};
      OP_NOR:  ctrl = '{grp: GRP_OR,  inv_b: 1'b0, inv_res: 1'b1};
      OP_XOR:  ctrl = '{grp: GRP_XOR, inv_b: 1'b0, inv_res: 1'b0};
      OP_EQV:  ctrl = '{grp: GRP_XOR, inv_b: 1'b0, inv_res: 1'b1};
      default: ctrl = '0;
    endcase
  end

  assign grp_sel = ctrl.grp;
  assign inv_b   = ctrl.inv_b;
  assign inv_res = ctrl.inv_res;
endmodule

// File: rtl/lgu_b_cond.sv
module lgu_b_cond #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             inv,
  output logic [WIDTH-1:0] b_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  always_comb b_out = inv ? (b_in ^ ALL_ONES) : b_in;
endmodule

// File: rtl/lgu_core.sv
module lgu_core
  import lgu_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       grp,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (lgu_grp_e'(grp))
        GRP_AND: y[i] = a[i] & b[i];
        GRP_OR:  y[i] = a[i] | b[i];
        GRP_XOR: y[i] = a[i] ^ b[i];
        default: y[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lgu_out_cond.sv
module lgu_out_cond
  import lgu_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] core_y,
  input  logic [1:0]       grp,
  input  logic             inv,
  output logic [WIDTH-1:0] y
);
  logic flip;

  always_comb flip = inv && (lgu_grp_e'(grp) != GRP_RSVD);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb y[i] = core_y[i] ^ flip;
  end
endmodule

// File: rtl/lgu_logic_unit.sv
module lgu_logic_unit #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       grp_sel,
  input  logic             inv_b,
  input  logic             inv_res,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] b_cond;
  logic [WIDTH-1:0] core_y;

  lgu_b_cond #(.WIDTH(WIDTH)) u_bcond (
    .b_in  (opb),
    .inv   (inv_b),
    .b_out (b_cond)
  );

  lgu_core #(.WIDTH(WIDTH)) u_core (
    .a   (opa),
    .b   (b_cond),
    .grp (grp_sel),
    .y   (core_y)
  );

  lgu_out_cond #(.WIDTH(WIDTH)) u_ocond (
    .core_y (core_y),
    .grp    (grp_sel),
    .inv    (inv_res),
    .y      (result)
  );
endmodule

// File: rtl/lgu_logic_unit_chk.sv
module lgu_logic_unit_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [1:0]       grp_sel,
  input logic             inv_b,
  input logic             inv_res,
  input logic [WIDTH-1:0] result
);
  logic known;

  always_comb known = !$isunknown({opa, opb, grp_sel, inv_b, inv_res, result});

  always_comb begin
    if (known && grp_sel == 2'b00 && !inv_b && !inv_res)
      p_and_path_r1: assert (result == (opa & opb));
    if (known && grp_sel == 2'b01 && !inv_b && !inv_res)
      p_or_path_r2: assert (result == (opa | opb));
    if (known && grp_sel == 2'b10 && !inv_b && !inv_res)
      p_xor_path_r3: assert (result == (opa ^ opb));
    if (known && grp_sel == 2'b00 && inv_b && !inv_res)
      p_andc_path_r4: assert (result == (opa & ~opb));
    if (known && grp_sel == 2'b01 && !inv_b && inv_res)
      p_nor_path_r5: assert (result == ~(opa | opb));
    if (known && grp_sel == 2'b11)
      p_rsvd_zero_r6: assert (result == '0);
  end
endmodule

bind lgu_logic_unit lgu_logic_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .opa     (opa),
  .opb     (opb),
  .grp_sel (grp_sel),
  .inv_b   (inv_b),
  .inv_res (inv_res),
  .result  (result)
);

// File: tb/lgu_logic_unit_bench.sv
`timescale 1ns/1ps
module lgu_logic_unit_bench;
  localparam int W = 64;
  localparam int NV = 6;
  localparam logic [W-1:0] VA [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0123_4567_89AB_CDEF};
  localparam logic [W-1:0] VB [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0, 64'h5555_5555_5555_5555, 64'hF0F0_0FF0_3C3C_C3A5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] opa, opb, result;
  logic [2:0]   op_code;
  logic [1:0]   d_grp, grp_sel;
  logic         d_invb, d_invr, inv_b, inv_res, use_dec;
  logic [1:0]   m_grp;
  logic         m_invb, m_invr;

  assign grp_sel = use_dec ? d_grp  : m_grp;
  assign inv_b   = use_dec ? d_invb : m_invb;
  assign inv_res = use_dec ? d_invr : m_invr;

  lgu_op_decode u_dec (
    .op_code (op_code), .grp_sel (d_grp), .inv_b (d_invb), .inv_res (d_invr));

  lgu_logic_unit u_lgu_logic_unit (
    .opa (opa), .opb (opb), .grp_sel (grp_sel),
    .inv_b (inv_b), .inv_res (inv_res), .result (result));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] ref_op(int op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      0: return a & b;
      1: return a & ~b;
      2: return ~(a & b);
      3: return a | b;
      4: return a | ~b;
      5: return ~(a | b);
      6: return a ^ b;
      default: return ~(a ^ b);
    endcase
  endfunction

  function automatic logic [3:0] ref_ctrl(int op);
    case (op)
      0: return 4'b00_0_0;
      1: return 4'b00_1_0;
      2: return 4'b00_0_1;
      3: return 4'b01_0_0;
      4: return 4'b01_1_0;
      5: return 4'b01_0_1;
      6: return 4'b10_0_0;
      default: return 4'b10_0_1;
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_all_ops(logic [W-1:0] a, logic [W-1:0] b);
    for (int op = 0; op < 8; op++) begin
      @(negedge clk);
      use_dec = 1'b1; op_code = 3'(op); opa = a; opb = b;
      #1;
      chk("R7 decode", {60'd0, d_grp, d_invb, d_invr}, {60'd0, ref_ctrl(op)});
      case (op)
        0: chk("R1 and", result, ref_op(op, a, b));
        1, 4: chk("R4 inv_b", result, ref_op(op, a, b));
        2, 5, 7: chk("R5 inv_res", result, ref_op(op, a, b));
        3: chk("R2 or", result, ref_op(op, a, b));
        default: chk("R3 xor", result, ref_op(op, a, b));
      endcase
    end
  endtask

  initial begin
    opa = '0; opb = '0; op_code = '0; use_dec = 1'b0;
    m_grp = 2'b11; m_invb = 1'b0; m_invr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R6 idle reserved zero", result, '0);

    for (int v = 0; v < NV; v++) run_all_ops(VA[v], VB[v]);
    for (int r = 0; r < 20; r++)
      run_all_ops({$urandom, $urandom}, {$urandom, $urandom});

    // R6: reserved group, all flag combinations, all-ones operands
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      use_dec = 1'b0; m_grp = 2'b11; m_invb = f[0]; m_invr = f[1];
      opa = '1; opb = (f == 2) ? '0 : '1;
      #1;
      chk("R6 reserved", result, '0);
    end

    // R4+R5 together on OR path: ~(a | ~b)
    @(negedge clk);
    use_dec = 1'b0; m_grp = 2'b01; m_invb = 1'b1; m_invr = 1'b1;
    opa = 64'h00FF_00FF_1234_5678; opb = 64'h0F0F_F0F0_FFFF_0000;
    #1;
    chk("R5 both flags", result, ~(opa | ~opb));

    // R8: no clock edge between input change and check
    @(negedge clk);
    use_dec = 1'b0; m_grp = 2'b10; m_invb = 1'b0; m_invr = 1'b0;
    opa = 64'hDEAD_BEEF_0000_FFFF; opb = 64'h0;
    #0.5;
    chk("R8 comb step1", result, 64'hDEAD_BEEF_0000_FFFF);
    opb = 64'hFFFF_FFFF_FFFF_FFFF;
    #0.5;
    chk("R8 comb step2", result, ~64'hDEAD_BEEF_0000_FFFF);
    m_grp = 2'b00;
    #0.5;
    chk("R8 comb step3", result, 64'hDEAD_BEEF_0000_FFFF);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule